// File: doc/BRIEF.md
# Page Access Rights and Fault Prioritizer

This block decides what an access to an already-translated page may do. It receives the protection fields of the page entry that matched, the privilege level of the requester, the kind of access (load, store or fetch), a switch that turns protection-id checking on, and four protection-id registers. From these it works out the permission set the page grants at that privilege and, when the access cannot go ahead, picks exactly one fault code. The physical address supplied with the request is carried alongside.

Privilege is two bits, 0 being the most privileged. Each entry holds two privilege bounds. The upper bound limits reads and fetches. The lower bound limits writes and sets the floor of the execute window. A three-bit page type picks which of the three rights the page may grant. Three status bits can still turn an allowed access into a fault: a clean-page bit, a break bit and a reference-trap bit. When several of these apply, the one with the highest priority wins. Every result goes through one register stage and comes out with a valid strobe.

Top module: `ar_rights_check`

## Requirements
- R1: Each cycle with `req_valid` high yields `rsp_valid` high on the next cycle, with `rsp_paddr` equal to the request's address. A cycle with `req_valid` low yields `rsp_valid` low. Synchronous active-low reset clears `rsp_valid`, `rsp_fault` and `rsp_code`.
- R2: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Read needs priv <= upper bound (`ent_pl1`). Write needs priv <= lower bound (`ent_pl2`). Execute needs lower bound <= priv <= upper bound.
- R3: Types 0 to 3 grant these rights, each still subject to its R2 window:
  - type 0: read
  - type 1: read and write
  - type 2: read and execute
  - type 3: read, write and execute
- R4: Types 4 to 7 grant only execute, under the R2 execute window, whatever their low two bits are.
- R5: A protection-id hit happens only when all of these hold:
  - `chk_en` is 1;
  - `ent_aid` is not 0;
  - some 32-bit register in `pid_regs` equals the access id shifted left one place with bit 0 set. Register k sits at bits [32k+31:32k].

  A hit removes write from the granted set. A store that hits gets fault code 3 (protection id).
- R6: When `ent_aid` is 0 or `chk_en` is 0, the protection-id registers have no effect.
- R7: If the access needs a right that is not in the granted set, the code is 1 (instruction protection) for a fetch and 2 (data access rights) otherwise. A protection-id fault takes precedence over this check.
- R8: Once an access passes R5 and R7, a clear `ent_dirty` removes write from the set, and a store gets code 4 (dirty).
- R9: Once an access passes R5 and R7, a set `ent_brk` removes write from the set, and a store gets code 5 (break). This overrides code 4.
- R10: Once an access passes R5 and R7, a set `ent_trap` removes read and write from the set. Any access that is not a fetch gets code 6 (page reference). This overrides codes 4 and 5.
- R11: `req_kind` uses these encodings: 0 load, 1 store, 2 fetch, and 3 treated exactly as a load.
- R12: `rsp_fault` is 1 exactly when `rsp_code` is not 0. With no fault, the code is 0 and `rsp_perm` is the set left after R2 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind (R11) |
| req_priv | input | 2 | Requester privilege, 0 most privileged |
| req_paddr | input | PA_W | Physical address to carry through |
| ent_pl1 | input | 2 | Upper privilege bound |
| ent_pl2 | input | 2 | Lower privilege bound |
| ent_type | input | 3 | Page type |
| ent_aid | input | AID_W | Access id, 0 = public page |
| ent_dirty | input | 1 | Page-written bit |
| ent_brk | input | 1 | Break-on-write bit |
| ent_trap | input | 1 | Reference-trap bit |
| chk_en | input | 1 | Protection-id check enable |
| pid_regs | input | NUM_PID*PID_W | Protection-id registers, packed |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | PA_W | Carried address |
| rsp_perm | output | 3 | Granted rights |
| rsp_fault | output | 1 | A fault was raised |
| rsp_code | output | 3 | Fault code |

## Verification
The bench aims at the points where two rules overlap. One is a store that hits a protection id on a page that would otherwise fail its rights check: a design that reordered these checks would report code 2 instead of 3. Another is a page with all three status bits active: a design that let the earlier checks win would report dirty or break instead of page reference. A third is a fetch on a trapped page: this must pass with read and write stripped, while a wrong design faults it or leaves those rights set. The bench also tries privilege exactly on a bound, execute-only types whose low bits vary, a protection-id register with bit 0 clear, and kind code 3. A mistake in any of these shows up as a wrong permission set or a wrong code.

// File: rtl/ar_pkg.sv
// Shared encodings for the access rights checker.
// Assumes permission vectors are indexed by the PERM_* constants.
package ar_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_IPROT   = 3'd1,
        FLT_DRIGHTS = 3'd2,
        FLT_PID     = 3'd3,
        FLT_DIRTY   = 3'd4,
        FLT_BREAK   = 3'd5,
        FLT_PAGEREF = 3'd6
    } fault_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_N = 3;
endpackage

// File: rtl/ar_perm_decode.sv
// Base permission decode: applies the privilege windows to the page type.
// Assumes privilege 0 is most privileged; types 4..7 are execute-only.
module ar_perm_decode
    import ar_pkg::*;
#(
    parameter int PRIV_W = 2,
    parameter int TYPE_W = 3
) (
    input  logic [PRIV_W-1:0] priv,
    input  logic [PRIV_W-1:0] bound_hi,
    input  logic [PRIV_W-1:0] bound_lo,
    input  logic [TYPE_W-1:0] ptype,
    output logic [PERM_N-1:0] base_perm
);
    logic rd_ok;
    logic wr_ok;
    logic ex_ok;

    // Privilege windows for each right.
    always_comb begin
        rd_ok = (priv <= bound_hi);
        wr_ok = (priv <= bound_lo);
        ex_ok = (bound_lo <= priv) && (priv <= bound_hi);
    end

    // Page type selects which windows contribute.
    always_comb begin
        base_perm = '0;
        if (ptype[TYPE_W-1]) begin
            base_perm[PERM_X] = ex_ok;
        end else begin
            unique case (ptype[1:0])
                2'd0: base_perm[PERM_R] = rd_ok;
                2'd1: begin
                    base_perm[PERM_R] = rd_ok;
                    base_perm[PERM_W] = wr_ok;
                end
                2'd2: begin
                    base_perm[PERM_R] = rd_ok;
                    base_perm[PERM_X] = ex_ok;
                end
                default: begin
                    base_perm[PERM_R] = rd_ok;
                    base_perm[PERM_W] = wr_ok;
                    base_perm[PERM_X] = ex_ok;
                end
            endcase
        end
    end
endmodule

// File: rtl/ar_pid_match.sv
// Protection-id comparator: flags an entry whose id matches a register
// with its write-disable bit (bit 0) set. Assumes PID_W > AID_W + 1.
module ar_pid_match #(
    parameter int AID_W   = 18,
    parameter int PID_W   = 32,
    parameter int NUM_PID = 4
) (
    input  logic                     chk_en,
    input  logic [AID_W-1:0]         aid,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     pid_hit
);
    localparam int PAD_W = PID_W - AID_W - 1;

    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] slot_hit;

    // Reference pattern: id in bits [PID_W-1:1], bit 0 set.
    always_comb key = {{PAD_W{1'b0}}, aid, 1'b1};

    // One comparator per protection-id register.
    for (genvar k = 0; k < NUM_PID; k++) begin : g_slot
        always_comb slot_hit[k] = (pid_regs[k*PID_W +: PID_W] == key);
    end

    // Public pages and disabled checking never hit.
    always_comb pid_hit = chk_en && (aid != '0) && (|slot_hit);
endmodule

// File: rtl/ar_fault_sel.sv
// Fault prioritizer: applies the protection-id result, the rights check
// and the status bits in that order. Later status bits override earlier.
// Assumes base_perm already reflects the privilege windows.
module ar_fault_sel
    import ar_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [PERM_N-1:0] base_perm,
    input  logic              pid_hit,
    input  logic              dirty,
    input  logic              brk,
    input  logic              trap,
    output logic [PERM_N-1:0] perm,
    output fault_e            code
);
    logic              is_wr;
    logic              is_ex;
    logic [PERM_N-1:0] need;

    // Classify the access and the right it needs.
    always_comb begin
        is_wr = (acc_kind_e'(kind) == ACC_STORE);
        is_ex = (acc_kind_e'(kind) == ACC_FETCH);
        need  = '0;
        if (is_wr)      need[PERM_W] = 1'b1;
        else if (is_ex) need[PERM_X] = 1'b1;
        else            need[PERM_R] = 1'b1;
    end

    // Priority chain producing the final set and a single code.
    always_comb begin
        perm = base_perm;
        code = FLT_NONE;
        if (pid_hit) begin
            perm[PERM_W] = 1'b0;
            if (is_wr) code = FLT_PID;
        end
        if (code == FLT_NONE) begin
            if ((perm & need) == '0) begin
                code = is_ex ? FLT_IPROT : FLT_DRIGHTS;
            end else begin
                if (!dirty) begin
                    perm[PERM_W] = 1'b0;
                    if (is_wr) code = FLT_DIRTY;
                end
                if (brk) begin
                    perm[PERM_W] = 1'b0;
                    if (is_wr) code = FLT_BREAK;
                end
                if (trap) begin
                    perm[PERM_R] = 1'b0;
                    perm[PERM_W] = 1'b0;
                    if (!is_ex) code = FLT_PAGEREF;
                end
            end
        end
    end
endmodule

// File: rtl/ar_rights_check.sv
// Top of the access rights checker: decodes rights, checks protection
// ids, prioritizes faults and registers the result for one cycle.
// Assumes the entry fields belong to an entry that already matched.
module ar_rights_check
    import ar_pkg::*;
#(
    parameter int PA_W    = 32,
    parameter int AID_W   = 18,
    parameter int PID_W   = 32,
    parameter int NUM_PID = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [1:0]               req_priv,
    input  logic [PA_W-1:0]          req_paddr,
    input  logic [1:0]               ent_pl1,
    input  logic [1:0]               ent_pl2,
    input  logic [2:0]               ent_type,
    input  logic [AID_W-1:0]         ent_aid,
    input  logic                     ent_dirty,
    input  logic                     ent_brk,
    input  logic                     ent_trap,
    input  logic                     chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     rsp_valid,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic [2:0]               rsp_perm,
    output logic                     rsp_fault,
    output logic [2:0]               rsp_code
);
    logic [PERM_N-1:0] base_perm;
    logic [PERM_N-1:0] fin_perm;
    logic              pid_hit;
    fault_e            fin_code;

    ar_perm_decode #(.PRIV_W(2), .TYPE_W(3)) u_decode (
        .priv      (req_priv),
        .bound_hi  (ent_pl1),
        .bound_lo  (ent_pl2),
        .ptype     (ent_type),
        .base_perm (base_perm)
    );

    ar_pid_match #(.AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NUM_PID)) u_pid (
        .chk_en   (chk_en),
        .aid      (ent_aid),
        .pid_regs (pid_regs),
        .pid_hit  (pid_hit)
    );

    ar_fault_sel u_sel (
        .kind      (req_kind),
        .base_perm (base_perm),
        .pid_hit   (pid_hit),
        .dirty     (ent_dirty),
        .brk       (ent_brk),
        .trap      (ent_trap),
        .perm      (fin_perm),
        .code      (fin_code)
    );

    // Output stage: one register, valid strobe follows the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_fault <= 1'b0;
            rsp_code  <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= req_paddr;
                rsp_perm  <= fin_perm;
                rsp_fault <= (fin_code != FLT_NONE);
                rsp_code  <= fin_code;
            end
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_paddr == $past(req_paddr)));

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_flag_matches_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));

    assert_insn_fault_only_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd1) |-> ($past(req_kind) == 2'd2));

    assert_write_stripped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == 3'd3 || rsp_code == 3'd4 || rsp_code == 3'd5))
        |-> !rsp_perm[1]);

    assert_pageref_strips_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd6) |-> (rsp_perm[1:0] == 2'b00));
endmodule

// File: tb/ar_rights_check_bench.sv
module ar_rights_check_bench;
    localparam int PA_W = 32, AID_W = 18, PID_W = 32, NUM_PID = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic [1:0] req_kind, req_priv, ent_pl1, ent_pl2;
    logic [PA_W-1:0] req_paddr;
    logic [2:0] ent_type;
    logic [AID_W-1:0] ent_aid;
    logic ent_dirty, ent_brk, ent_trap, chk_en;
    logic [NUM_PID*PID_W-1:0] pid_regs;
    logic rsp_valid, rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic [2:0] rsp_perm, rsp_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ar_rights_check #(.PA_W(PA_W), .AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NUM_PID))
    u_ar_rights_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_priv(req_priv), .req_paddr(req_paddr), .ent_pl1(ent_pl1),
        .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_aid(ent_aid),
        .ent_dirty(ent_dirty), .ent_brk(ent_brk), .ent_trap(ent_trap),
        .chk_en(chk_en), .pid_regs(pid_regs), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code)
    );

    // Reference model from the requirements; returns {perm, code}.
    function automatic logic [5:0] model(input logic [1:0] kind, input logic [1:0] pv,
                                         input logic [1:0] hi, input logic [1:0] lo,
                                         input logic [2:0] ty, input logic [AID_W-1:0] aid,
                                         input logic d, input logic b, input logic t,
                                         input logic en, input logic [NUM_PID*PID_W-1:0] pids);
        bit r, w, x, hit, st, fe;
        logic [2:0] c;
        st = (kind == 2'd1);
        fe = (kind == 2'd2);
        r = 0; w = 0; x = 0;
        if (ty >= 3'd4) x = (pv >= lo) && (pv <= hi);
        else begin
            r = (pv <= hi);
            if (ty == 3'd1 || ty == 3'd3) w = (pv <= lo);
            if (ty == 3'd2 || ty == 3'd3) x = (pv >= lo) && (pv <= hi);
        end
        hit = 0;
        if (en && aid != 0)
            for (int k = 0; k < NUM_PID; k++)
                if (pids[k*PID_W +: PID_W] == ((32'(aid) << 1) | 32'd1)) hit = 1;
        c = 3'd0;
        if (hit) begin
            w = 0;
            if (st) c = 3'd3;
        end
        if (c == 0) begin
            if (st ? !w : (fe ? !x : !r)) c = fe ? 3'd1 : 3'd2;
            else begin
                if (t) begin
                    r = 0; w = 0;
                    if (!fe) c = 3'd6;
                end else if (b) begin
                    w = 0;
                    if (st) c = 3'd5;
                end else if (!d) begin
                    w = 0;
                    if (st) c = 3'd4;
                end
            end
        end
        return {x, w, r, c};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_entry(input logic [1:0] hi, input logic [1:0] lo, input logic [2:0] ty,
                             input logic [AID_W-1:0] aid, input logic d, input logic b,
                             input logic t, input logic en);
        ent_pl1 = hi; ent_pl2 = lo; ent_type = ty; ent_aid = aid;
        ent_dirty = d; ent_brk = b; ent_trap = t; chk_en = en;
    endtask

    // Drive one request, check the registered result one cycle later.
    task automatic run(input string tag, input logic [1:0] kind, input logic [1:0] pv,
                       input logic [PA_W-1:0] pa);
        logic [5:0] e;
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_priv = pv; req_paddr = pa;
        e = model(kind, pv, ent_pl1, ent_pl2, ent_type, ent_aid, ent_dirty, ent_brk,
                  ent_trap, chk_en, pid_regs);
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " paddr"}, rsp_paddr, pa);
        chk({tag, " perm"}, 32'(rsp_perm), 32'(e[5:3]));
        chk({tag, " code"}, 32'(rsp_code), 32'(e[2:0]));
        chk({tag, " R12 flag"}, 32'(rsp_fault), 32'(e[2:0] != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 0; req_valid = 1; req_kind = 0; req_priv = 0; req_paddr = 32'h1234;
        pid_regs = '0;
        set_entry(2'd3, 2'd3, 3'd3, '0, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(rsp_valid), 0);
        chk("R1 reset fault", 32'(rsp_fault), 0);
        chk("R1 reset code", 32'(rsp_code), 0);
        rst_n = 1; req_valid = 0;
        @(negedge clk);
        chk("R1 idle", 32'(rsp_valid), 0);

        // R2 window edges, R3 types
        set_entry(2'd2, 2'd1, 3'd3, '0, 1, 0, 0, 0);
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++) run("R2 window", 2'(k), 2'(p), 32'(p * 16 + k));
        for (int ty = 0; ty < 4; ty++) begin
            set_entry(2'd3, 2'd0, 3'(ty), '0, 1, 0, 0, 0);
            for (int k = 0; k < 3; k++) run("R3 type", 2'(k), 2'd0, 32'(ty));
        end
        // R4 execute-only, low bits vary
        for (int ty = 4; ty < 8; ty++) begin
            set_entry(2'd2, 2'd1, 3'(ty), '0, 1, 0, 0, 0);
            run("R4 exec", 2'd2, 2'd1, 32'hA0);
            run("R4 load", 2'd0, 2'd1, 32'hA1);
            run("R4 below window", 2'd2, 2'd0, 32'hA2);
        end
        // R5 pid hit in slot 2; store on write-less page still gives code 3 (R7 precedence)
        pid_regs = '0;
        pid_regs[2*32 +: 32] = (32'h155 << 1) | 1;
        set_entry(2'd3, 2'd3, 3'd0, 18'h155, 1, 0, 0, 1);
        run("R5 R7 pid precedence", 2'd1, 2'd0, 32'hB0);
        set_entry(2'd3, 2'd3, 3'd3, 18'h155, 1, 0, 0, 1);
        run("R5 store hit", 2'd1, 2'd0, 32'hB1);
        run("R5 load hit strips write", 2'd0, 2'd0, 32'hB2);
        pid_regs[2*32 +: 32] = (32'h155 << 1);
        run("R5 bit0 clear no hit", 2'd1, 2'd0, 32'hB3);
        // R6 ignored when disabled or public
        pid_regs[0 +: 32] = 32'd1;
        pid_regs[32 +: 32] = (32'h155 << 1) | 1;
        set_entry(2'd3, 2'd3, 3'd3, 18'h155, 1, 0, 0, 0);
        run("R6 disabled", 2'd1, 2'd0, 32'hC0);
        set_entry(2'd3, 2'd3, 3'd3, '0, 1, 0, 0, 1);
        run("R6 public", 2'd1, 2'd0, 32'hC1);
        // R7
        set_entry(2'd0, 2'd0, 3'd2, '0, 1, 0, 0, 0);
        run("R7 fetch denied", 2'd2, 2'd2, 32'hD0);
        run("R7 load denied", 2'd0, 2'd2, 32'hD1);
        // R8 R9 R10 status bits and overrides
        set_entry(2'd3, 2'd3, 3'd3, '0, 0, 0, 0, 0);
        run("R8 dirty store", 2'd1, 2'd0, 32'hE0);
        run("R8 dirty load", 2'd0, 2'd0, 32'hE1);
        set_entry(2'd3, 2'd3, 3'd3, '0, 0, 1, 0, 0);
        run("R9 break over dirty", 2'd1, 2'd0, 32'hE2);
        set_entry(2'd3, 2'd3, 3'd3, '0, 0, 1, 1, 0);
        run("R10 trap over all", 2'd1, 2'd0, 32'hE3);
        run("R10 trap fetch passes", 2'd2, 2'd0, 32'hE4);
        run("R11 alt kind as load", 2'd3, 2'd0, 32'hE5);

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [AID_W-1:0] a;
            a = ($urandom % 4 == 0) ? '0 : AID_W'($urandom % 8);
            for (int k = 0; k < NUM_PID; k++)
                pid_regs[k*32 +: 32] = ($urandom % 3 == 0) ? ((32'($urandom % 8) << 1) | 32'($urandom % 2))
                                                          : $urandom;
            set_entry(2'($urandom), 2'($urandom), 3'($urandom), a, 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
            run("R2 R3 R5 R8 R11 random", 2'($urandom), 2'($urandom), $urandom);
        end

        @(negedge clk);
        chk("R1 drop", 32'(rsp_valid), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule